// File: doc/BRIEF.md
# Vector-Priority Interrupt Controller

This block sits next to a processor core and decides which interrupt the core should take next. Each of its request lines has a vector number and a gate type, both of which software sets through a small write port. A rising edge on a request line marks that source as pending. Among the pending sources, the one with the highest vector wins. The priority class of a vector is its upper four bits (vector / 16).

The winner is offered to the core only when three conditions hold. The core's interrupt-enable flag must be set. The winner's class must be strictly above the task-priority class. It must also be strictly above the class of the highest vector already in service. The core takes the offered vector by acknowledging it. The vector is then tracked as in service until an end-of-interrupt signal retires it. Vectors below 32 are reserved for exceptions and can never be programmed.

The delivery side is a valid/ready pair. `irq_valid` offers `irq_vector` and `irq_trap`, and `irq_ack` is the ready. A transfer happens only in a cycle where both are high. When `irq_ack` is low the offer simply waits, and nothing is lost. An offer is not a commitment: `irq_valid` may drop before any acknowledge if the enable flag clears, if the task priority rises, or if a higher source arrives and replaces the vector. The configuration port and the end-of-interrupt pin are plain control.

Top module: `vpic_top`

## Requirements
- R1: Each source has its own vector register and gate-type bit. After reset, source i holds vector 32+i with gate type 0.
- R2: The presented vector belongs to the highest vector among the pending sources. When two pending sources share a vector, the lower source index wins.
- R3: `irq_vector` is never below 32 while `irq_valid` is high.
- R4: `irq_valid` is high only when all of the following hold: a source is pending, `if_flag` is 1, the winner's class (`vector[7:4]`) is strictly greater than `tpr`, and the winner's class is strictly greater than the class of the highest in-service vector (taken as 0 when nothing is in service).
- R5: A configuration write with a vector below 32 is rejected. The source's vector and gate type stay as they were, and `cfg_err` is high for exactly the next cycle. An accepted write leaves `cfg_err` low.
- R6: A 0-to-1 change on a request line (sampled at the clock) makes that source pending. A further rising edge while the source is still pending is merged, so it yields only one delivery.
- R7: In a cycle with `irq_valid` and `irq_ack` both high, the winning source stops being pending and its vector enters the in-service set. `irq_ack` without `irq_valid` changes nothing.
- R8: `eoi` removes the highest vector from the in-service set. If `eoi` and an accepted acknowledge occur in the same cycle, `eoi` acts on the set as it stood before that acknowledge.
- R9: `irq_trap` gives the gate type of the presented vector. 1 means a trap gate, which leaves the enable flag alone. 0 means an interrupt gate, which clears the enable flag on entry.
- R10: A rising edge on the winning source in the very cycle it is acknowledged leaves that source pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_req | input | NSRC | Request lines, edge sensitive |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | $clog2(NSRC) | Source being programmed |
| cfg_vec | input | 8 | Vector to program |
| cfg_trap | input | 1 | Gate type to program (1 = trap) |
| cfg_err | output | 1 | Rejected-write flag, one cycle |
| if_flag | input | 1 | Core interrupt-enable flag |
| tpr | input | 4 | Task-priority class |
| irq_valid | output | 1 | Interrupt offered |
| irq_vector | output | 8 | Offered vector |
| irq_trap | output | 1 | Gate type of the offered vector |
| irq_ack | input | 1 | Core accepts the offered interrupt (ready) |
| eoi | input | 1 | End of interrupt |

## Verification
The bench aims at the strict comparisons. A class equal to `tpr` or equal to the in-service class must stay blocked. A design that used greater-or-equal would let a handler be re-entered at its own level. Merged edges are also targeted: a design that counted edges would deliver the same source twice. The bench covers an edge that arrives in the acknowledge cycle, which a careless clear would lose. It covers an `eoi` that coincides with an acknowledge, which a wrong ordering would apply to the vector just accepted. Finally, it covers rejected low vectors: a design that accepted them would later offer a reserved vector.

// File: rtl/vpic_pkg.sv
package vpic_pkg;
  localparam int VEC_W      = 8;
  localparam int NVEC       = 1 << VEC_W;
  localparam int CLS_W      = 4;
  localparam int FIRST_USER = 32;

  function automatic logic [CLS_W-1:0] cls_of(input logic [VEC_W-1:0] v);
    return v[VEC_W-1 -: CLS_W];
  endfunction
endpackage

// File: rtl/vpic_src_bank.sv
module vpic_src_bank
  import vpic_pkg::*;
#(
  parameter int NSRC = 8,
  localparam int IW = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NSRC-1:0]       req,
  input  logic                  cfg_we,
  input  logic [IW-1:0]         cfg_idx,
  input  logic [VEC_W-1:0]      cfg_vec,
  input  logic                  cfg_trap,
  input  logic                  clr_en,
  input  logic [IW-1:0]         clr_idx,
  output logic [NSRC*VEC_W-1:0] vec_flat,
  output logic [NSRC-1:0]       trap_bits,
  output logic [NSRC-1:0]       pending,
  output logic                  cfg_err
);
  logic [NSRC-1:0] req_q;
  logic            reject;

  assign reject = cfg_we && (cfg_vec < VEC_W'(FIRST_USER));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_q   <= '0;
      cfg_err <= 1'b0;
    end else begin
      req_q   <= req;
      cfg_err <= reject;
    end
  end

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    logic rise;
    assign rise = req[i] && !req_q[i];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        vec_flat[i*VEC_W +: VEC_W] <= VEC_W'(FIRST_USER + i);
        trap_bits[i]               <= 1'b0;
        pending[i]                 <= 1'b0;
      end else begin
        if (cfg_we && !reject && cfg_idx == IW'(i)) begin
          vec_flat[i*VEC_W +: VEC_W] <= cfg_vec;
          trap_bits[i]               <= cfg_trap;
        end
        pending[i] <= rise || (pending[i] && !(clr_en && clr_idx == IW'(i)));
      end
    end

    // R6 / R10: a sampled rising edge always leaves the source pending
    a_r6_edge_pends: assert property (@(posedge clk) disable iff (!rst_n)
      (req[i] && !req_q[i]) |=> pending[i]);
  end

  // R5: rejected write raises the error flag and leaves the table untouched
  a_r5_err_on_reject: assert property (@(posedge clk) disable iff (!rst_n)
    reject |=> cfg_err);
  a_r5_table_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (reject && !$past(!rst_n)) |=> ($stable(vec_flat) && $stable(trap_bits)));
endmodule

// File: rtl/vpic_arbiter.sv
module vpic_arbiter
  import vpic_pkg::*;
#(
  parameter int NSRC = 8,
  localparam int IW = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic [NSRC*VEC_W-1:0] vec_flat,
  input  logic [NSRC-1:0]       trap_bits,
  input  logic [NSRC-1:0]       pending,
  output logic                  any,
  output logic [IW-1:0]         win_idx,
  output logic [VEC_W-1:0]      win_vec,
  output logic                  win_trap
);
  always_comb begin
    any      = 1'b0;
    win_idx  = '0;
    win_vec  = '0;
    win_trap = 1'b0;
    for (int i = 0; i < NSRC; i++) begin
      if (pending[i] && (!any || vec_flat[i*VEC_W +: VEC_W] > win_vec)) begin
        any      = 1'b1;
        win_idx  = IW'(i);
        win_vec  = vec_flat[i*VEC_W +: VEC_W];
        win_trap = trap_bits[i];
      end
    end
  end
endmodule

// File: rtl/vpic_isr_track.sv
module vpic_isr_track
  import vpic_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_en,
  input  logic [VEC_W-1:0] set_vec,
  input  logic             eoi,
  output logic [CLS_W-1:0] top_cls,
  output logic             busy
);
  logic [NVEC-1:0]  isr_q;
  logic [VEC_W-1:0] top_vec;

  always_comb begin
    busy    = 1'b0;
    top_vec = '0;
    for (int v = 0; v < NVEC; v++) begin
      if (isr_q[v]) begin
        busy    = 1'b1;
        top_vec = VEC_W'(v);
      end
    end
  end

  assign top_cls = busy ? cls_of(top_vec) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      isr_q <= '0;
    end else begin
      for (int v = 0; v < NVEC; v++) begin
        if (set_en && set_vec == VEC_W'(v))
          isr_q[v] <= 1'b1;
        else if (eoi && busy && top_vec == VEC_W'(v))
          isr_q[v] <= 1'b0;
      end
    end
  end

  // R7: an accepted vector is in service afterwards
  a_r7_ack_in_service: assert property (@(posedge clk) disable iff (!rst_n)
    set_en |=> busy);
  // R8: eoi with nothing new accepted never raises the in-service class
  a_r8_eoi_lowers: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi && !set_en) |=> (top_cls <= $past(top_cls)));
endmodule

// File: rtl/vpic_top.sv
module vpic_top
  import vpic_pkg::*;
#(
  parameter int NSRC = 8,
  localparam int IW = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSRC-1:0]  src_req,
  input  logic             cfg_we,
  input  logic [IW-1:0]    cfg_idx,
  input  logic [VEC_W-1:0] cfg_vec,
  input  logic             cfg_trap,
  output logic             cfg_err,
  input  logic             if_flag,
  input  logic [CLS_W-1:0] tpr,
  output logic             irq_valid,
  output logic [VEC_W-1:0] irq_vector,
  output logic             irq_trap,
  input  logic             irq_ack,
  input  logic             eoi
);
  logic [NSRC*VEC_W-1:0] vec_flat;
  logic [NSRC-1:0]       trap_bits;
  logic [NSRC-1:0]       pending;
  logic                  any;
  logic [IW-1:0]         win_idx;
  logic [VEC_W-1:0]      win_vec;
  logic                  win_trap;
  logic [CLS_W-1:0]      isr_cls;
  logic                  isr_busy;
  logic                  take;

  vpic_src_bank #(.NSRC(NSRC)) u_bank (
    .clk(clk), .rst_n(rst_n), .req(src_req),
    .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_vec(cfg_vec), .cfg_trap(cfg_trap),
    .clr_en(take), .clr_idx(win_idx),
    .vec_flat(vec_flat), .trap_bits(trap_bits), .pending(pending), .cfg_err(cfg_err)
  );

  vpic_arbiter #(.NSRC(NSRC)) u_arb (
    .vec_flat(vec_flat), .trap_bits(trap_bits), .pending(pending),
    .any(any), .win_idx(win_idx), .win_vec(win_vec), .win_trap(win_trap)
  );

  vpic_isr_track u_isr (
    .clk(clk), .rst_n(rst_n), .set_en(take), .set_vec(win_vec), .eoi(eoi),
    .top_cls(isr_cls), .busy(isr_busy)
  );

  assign irq_valid  = any && if_flag && (cls_of(win_vec) > tpr) && (cls_of(win_vec) > isr_cls);
  assign irq_vector = win_vec;
  assign irq_trap   = win_trap;
  assign take       = irq_valid && irq_ack;

  // R3: reserved vectors never reach the core
  a_r3_no_reserved: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> (irq_vector >= VEC_W'(FIRST_USER)));
  // R4: an offer is never made while the core has interrupts disabled
  a_r4_if_gate: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> if_flag);
  // R4: a new acceptance always comes from a class above the one in service
  a_r4_nesting: assert property (@(posedge clk) disable iff (!rst_n)
    (take && isr_busy) |-> (cls_of(irq_vector) > isr_cls));
endmodule

// File: tb/vpic_top_bench.sv
module vpic_top_bench;
  localparam int N = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [N-1:0] src_req = '0;
  logic       cfg_we = 1'b0;
  logic [2:0] cfg_idx = '0;
  logic [7:0] cfg_vec = '0;
  logic       cfg_trap = 1'b0;
  logic       cfg_err;
  logic       if_flag = 1'b0;
  logic [3:0] tpr = '0;
  logic       irq_valid;
  logic [7:0] irq_vector;
  logic       irq_trap;
  logic       irq_ack = 1'b0;
  logic       eoi = 1'b0;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  // reference state
  logic [7:0] m_vec [N];
  logic       m_trap [N];
  logic [N-1:0] m_pend, m_prev;
  logic [255:0] m_isr;
  logic       m_err;

  always #5 clk = ~clk;

  vpic_top #(.NSRC(N)) u_vpic_top (
    .clk(clk), .rst_n(rst_n), .src_req(src_req),
    .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_vec(cfg_vec), .cfg_trap(cfg_trap),
    .cfg_err(cfg_err), .if_flag(if_flag), .tpr(tpr),
    .irq_valid(irq_valid), .irq_vector(irq_vector), .irq_trap(irq_trap),
    .irq_ack(irq_ack), .eoi(eoi)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int isr_top();
    for (int v = 255; v >= 0; v--) if (m_isr[v]) return v;
    return -1;
  endfunction

  // R2: highest vector, lowest index on ties
  function automatic int win();
    int w = -1;
    for (int i = 0; i < N; i++)
      if (m_pend[i] && (w < 0 || m_vec[i] > m_vec[w])) w = i;
    return w;
  endfunction

  // R4: offer conditions
  function automatic bit exp_valid();
    int w = win();
    int t = isr_top();
    int icls = (t < 0) ? 0 : t / 16;
    if (w < 0 || !if_flag) return 0;
    return (int'(m_vec[w]) / 16 > int'(tpr)) && (int'(m_vec[w]) / 16 > icls);
  endfunction

  task automatic model_reset();
    for (int i = 0; i < N; i++) begin m_vec[i] = 8'(32 + i); m_trap[i] = 1'b0; end
    m_pend = '0; m_prev = '0; m_isr = '0; m_err = 1'b0;
  endtask

  // one cycle: inputs already driven; compare, then advance the model at the edge
  task automatic step();
    int w;
    bit v;
    int t;
    #1;
    w = win();
    v = exp_valid();
    check("R4 valid", irq_valid, v);
    if (v) begin
      check("R2 vector", irq_vector, m_vec[w]);
      check("R9 gate", irq_trap, m_trap[w]);
      check("R3 range", irq_vector >= 32, 1);
    end
    check("R5 err", cfg_err, m_err);
    @(posedge clk);
    t = isr_top();
    if (eoi && t >= 0) m_isr[t] = 1'b0;          // R8: old set
    if (v && irq_ack) begin                      // R7
      m_pend[w] = 1'b0;
      m_isr[m_vec[w]] = 1'b1;
    end
    m_pend = m_pend | (src_req & ~m_prev);       // R6, R10
    m_prev = src_req;
    m_err = cfg_we && cfg_vec < 32;
    if (cfg_we && cfg_vec >= 32) begin m_vec[cfg_idx] = cfg_vec; m_trap[cfg_idx] = cfg_trap; end
    @(negedge clk);
    src_req = '0; cfg_we = 0; irq_ack = 0; eoi = 0;
  endtask

  task automatic prog(input int idx, input int vec, input bit tr);
    cfg_we = 1; cfg_idx = 3'(idx); cfg_vec = 8'(vec); cfg_trap = tr;
    step();
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state: no offer, no error
    check("R1 reset valid", irq_valid, 0);
    check("R1 reset err", cfg_err, 0);
    if_flag = 1;
    // R1: default vector of source 3 is 35
    src_req = 8'h08; step();
    check("R1 default vector", irq_vector, 35);
    step();
    // R5: rejected programming, then next cycle flag drops
    prog(3, 31, 1);
    step();
    check("R5 vector kept", irq_vector, 35);
    check("R9 gate kept", irq_trap, 0);
    irq_ack = 1; step();                         // take 35 (class 2)
    // R4: equal class in service blocks; vector 40 is class 2
    prog(0, 40, 1);
    src_req = 8'h01; step();
    check("R4 same class blocked", irq_valid, 0);
    eoi = 1; step();                             // retire 35
    check("R4 released", irq_valid, 1);
    check("R9 trap gate", irq_trap, 1);
    // R4: tpr equal blocks
    tpr = 2; step();
    check("R4 tpr equal blocked", irq_valid, 0);
    tpr = 0;
    // R6: merged edge; R2 ties: sources 1 and 2 at 80, lower index wins
    prog(1, 80, 0); prog(2, 80, 1);
    src_req = 8'h06; step();
    src_req = 8'h00; step();
    src_req = 8'h02; step();                     // second edge on source 1, merged
    check("R2 tie index", irq_trap, 0);
    irq_ack = 1; step();                         // take src1
    eoi = 1; step();
    check("R6 tie partner next", irq_trap, 1);
    irq_ack = 1; eoi = 1; step();                // R8 with simultaneous ack
    eoi = 1; step();
    // R10: edge in the ack cycle of the winner
    src_req = 8'h04; step();
    irq_ack = 1; src_req = 8'h00; step();
    src_req = 8'h04; step();
    irq_ack = 1; src_req = 8'h00; step();
    src_req = 8'h04; irq_ack = 1; step();
    check("R10 still pending", irq_valid, 0);    // blocked by in-service class 5
    eoi = 1; step(); eoi = 1; step(); eoi = 1; step();
    check("R10 re-offered", irq_valid, 1);
    // random phase
    for (int k = 0; k < 3000; k++) begin
      src_req  = N'($urandom);
      if_flag  = ($urandom % 8) != 0;
      tpr      = ($urandom % 4 == 0) ? 4'($urandom) : 4'd0;
      irq_ack  = $urandom % 2;
      eoi      = ($urandom % 3) == 0;
      if ($urandom % 6 == 0) begin
        cfg_we = 1; cfg_idx = 3'($urandom); cfg_vec = 8'($urandom); cfg_trap = $urandom % 2;
      end
      step();
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule